// File: doc/BRIEF.md
# Prescaled Interval Timer Pair with Match Clear

This block holds two 8-bit interval timers that run on the system clock. A shared free-running divider feeds each timer a one-cycle tick enable. The tick comes from one of four divider taps, and a global range bit moves all four taps one octave slower. While its run bit is high, a timer adds one to its count on every tick. On the tick where the incremented count equals the timer's compare register, the count goes back to zero and the interrupt line pulses for one cycle. Counting then carries on without a pause, so the interrupt repeats every (compare value × tick period) clock cycles.

Each compare register has a write strobe and shares one write-data bus with the other. A write changes the comparison at once: there is no shadow copy. When the chain bit is set, the two timers form one 16-bit interval timer. The lower counter wraps and carries into the upper one. A single compare on {upper, lower} clears both counters and pulses the upper interrupt line. In that mode the lower run bit and the lower source select control the pair.

Top module: `itmr_pair`

## Requirements
- R1: After synchronous reset both interrupt outputs are low, both counters are zero and both compare registers are zero. While both run bits stay low, no interrupt occurs.
- R2: Source select code 0, 1, 2, 3 gives a tick every 2^11, 2^7, 2^5, 2^3 clock cycles when the range bit is 0. It gives a tick every 2^12, 2^8, 2^6, 2^4 clock cycles when the range bit is 1.
- R3: A running timer adds one per tick. When the incremented count equals its compare value, the counter clears and the interrupt pulses high for exactly one cycle. Consecutive pulses are exactly compare × tick-period cycles apart.
- R4: A compare value of 0 gives a repeat period of 256 ticks (65536 in chained mode).
- R5: A compare write takes effect at once. Lowering the compare above the current count shortens the period now in progress.
- R6: If the compare is written at or below the current count, the counter runs up to 255, wraps to 0 and matches on the next pass. The next pulse comes (256 + new value) ticks after the previous one, with no pulse in between.
- R7: A low run bit freezes the counter and no interrupt occurs. A rising run bit clears the counter to zero before counting resumes.
- R8: With the chain bit low, the two timers run independently, each with its own run bit, source select and compare value. Each pulses only its own interrupt line.
- R9: With the chain bit high, the pair counts 16 bits and matches against {upper compare, lower compare}. The interrupt appears only on the upper line and the lower line stays low. The upper run bit and upper source select are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_en | input | 1 | 1: cascade both timers into one 16-bit timer |
| div_range | input | 1 | Global tap range: 1 moves every tap one octave slower |
| run_lo | input | 1 | Run bit of the lower timer (also of the chained pair) |
| run_hi | input | 1 | Run bit of the upper timer when not chained |
| src_sel_lo | input | 2 | Tick source select, lower timer (and chained pair) |
| src_sel_hi | input | 2 | Tick source select, upper timer when not chained |
| cmp_we_lo | input | 1 | Write strobe for the lower compare register |
| cmp_we_hi | input | 1 | Write strobe for the upper compare register |
| cmp_wdata | input | 8 | Compare write data |
| irq_lo | output | 1 | One-cycle match pulse of the lower timer |
| irq_hi | output | 1 | One-cycle match pulse of the upper timer or the chained pair |

## Verification
The bench measures the exact spacing of interrupt pulses for every tap and range combination. A mis-wired tap therefore shows up as a period off by a power of two. Compare writes made mid-period check the unbuffered path: a buffered register would keep the old period. Writes below the running count check the wrap-around: a design that compares with "greater or equal" would fire early instead of after 256 + N ticks. Stop and restart checks that a frozen count is discarded, because a design that resumed from the old count would interrupt too soon. Chained runs at a compare value above 255 check that the carry and the 16-bit clear work and that the lower line stays silent.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int CNT_W = 8;
    localparam int PRE_W = 12;
    localparam int EXP_W = 4;

    typedef enum logic [1:0] {
        SRC_DIV_XL = 2'd0,
        SRC_DIV_L  = 2'd1,
        SRC_DIV_M  = 2'd2,
        SRC_DIV_S  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic run;
        logic tick;
        logic clr;
    } unit_ctl_t;

    // Divider exponent: the tick period is 2^exp clock cycles.
    function automatic logic [EXP_W-1:0] tap_exp(input src_sel_e sel, input logic rng);
        logic [EXP_W-1:0] base;
        case (sel)
            SRC_DIV_XL: base = EXP_W'(11);
            SRC_DIV_L:  base = EXP_W'(7);
            SRC_DIV_M:  base = EXP_W'(5);
            default:    base = EXP_W'(3);
        endcase
        return base + EXP_W'(rng);
    endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] taps
);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + PW'(1);
    end

    // taps[k] is high for one cycle in every 2^(k+1), on the rising edge of bit k
    for (genvar k = 0; k < PW; k++) begin : g_tap
        localparam logic [PW-1:0] MSK = PW'((64'd1 << (k + 1)) - 64'd1);
        localparam logic [PW-1:0] HIT = PW'(64'd1 << k);
        assign taps[k] = ((div_q & MSK) == HIT);
    end

    AST_TAPS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(taps)); // R2

endmodule

// File: rtl/itmr_tap_sel.sv
module itmr_tap_sel
    import itmr_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic [PW-1:0] taps,
    input  logic [1:0]    sel,
    input  logic          rng,
    output logic          tick
);

    logic [EXP_W-1:0] exp_v;

    always_comb begin
        exp_v = tap_exp(src_sel_e'(sel), rng);
        tick  = taps[exp_v - EXP_W'(1)];
    end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         active
);

    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= run;
            if (run && !run_q)  cnt <= '0;
            else if (run && clr)  cnt <= '0;
            else if (run && tick) cnt <= cnt + W'(1);
        end
    end

    assign active = run & run_q;

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt)); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (run && !run_q) |=> (cnt == '0)); // R7
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !clr) |=> (cnt == W'($past(cnt) + W'(1)))); // R3

endmodule

// File: rtl/itmr_pair.sv
module itmr_pair
    import itmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chain_en,
    input  logic          div_range,
    input  logic          run_lo,
    input  logic          run_hi,
    input  logic [1:0]    src_sel_lo,
    input  logic [1:0]    src_sel_hi,
    input  logic          cmp_we_lo,
    input  logic          cmp_we_hi,
    input  logic [CW-1:0] cmp_wdata,
    output logic          irq_lo,
    output logic          irq_hi
);

    localparam int CW2 = 2 * CW;

    logic [PW-1:0] taps;
    logic          tsrc_lo, tsrc_hi;
    logic [CW-1:0] cmp_lo_q, cmp_hi_q;
    logic [CW-1:0] cnt_lo, cnt_hi;
    logic          act_lo, act_hi;
    logic [CW-1:0] lo_nxt, hi_nxt_sep, hi_nxt_ch;
    logic          carry, hit_lo, hit_hi, hit16;
    unit_ctl_t     ctl_lo, ctl_hi;

    itmr_prescaler #(.PW(PW)) u_presc (
        .clk (clk),
        .rst (rst),
        .taps(taps)
    );

    itmr_tap_sel #(.PW(PW)) u_sel_lo (
        .taps(taps), .sel(src_sel_lo), .rng(div_range), .tick(tsrc_lo)
    );

    itmr_tap_sel #(.PW(PW)) u_sel_hi (
        .taps(taps), .sel(src_sel_hi), .rng(div_range), .tick(tsrc_hi)
    );

    // Unbuffered compare registers: a write is used on the very next tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
        end else begin
            if (cmp_we_lo) cmp_lo_q <= cmp_wdata;
            if (cmp_we_hi) cmp_hi_q <= cmp_wdata;
        end
    end

    always_comb begin
        lo_nxt     = cnt_lo + CW'(1);
        hi_nxt_sep = cnt_hi + CW'(1);
        carry      = act_lo & tsrc_lo & (cnt_lo == '1);
        hi_nxt_ch  = cnt_hi + CW'(carry);
        hit_lo     = act_lo & tsrc_lo & (lo_nxt == cmp_lo_q);
        hit_hi     = act_hi & tsrc_hi & (hi_nxt_sep == cmp_hi_q);
        hit16      = act_lo & tsrc_lo &
                     ({hi_nxt_ch, lo_nxt} == CW2'({cmp_hi_q, cmp_lo_q}));

        ctl_lo.run  = run_lo;
        ctl_lo.tick = tsrc_lo;
        ctl_lo.clr  = chain_en ? hit16 : hit_lo;

        ctl_hi.run  = chain_en ? run_lo : run_hi;
        ctl_hi.tick = chain_en ? carry  : tsrc_hi;
        ctl_hi.clr  = chain_en ? hit16  : hit_hi;
    end

    itmr_counter #(.W(CW)) u_cnt_lo (
        .clk   (clk),
        .rst   (rst),
        .run   (ctl_lo.run),
        .tick  (ctl_lo.tick),
        .clr   (ctl_lo.clr),
        .cnt   (cnt_lo),
        .active(act_lo)
    );

    itmr_counter #(.W(CW)) u_cnt_hi (
        .clk   (clk),
        .rst   (rst),
        .run   (ctl_hi.run),
        .tick  (ctl_hi.tick),
        .clr   (ctl_hi.clr),
        .cnt   (cnt_hi),
        .active(act_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= !chain_en && hit_lo;
            irq_hi <= chain_en ? hit16 : hit_hi;
        end
    end

    AST_IRQ_LO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_lo |=> !irq_lo); // R3
    AST_IRQ_HI_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_hi |=> !irq_hi); // R3
    AST_CHAIN_LO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (chain_en && $past(chain_en)) |-> !irq_lo); // R9
    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> $past(run_lo)); // R7

endmodule

// File: tb/itmr_pair_tb.sv
`timescale 1ns/1ps
module itmr_pair_tb_top;

    logic       clk, rst;
    logic       chain_en, div_range, run_lo, run_hi;
    logic [1:0] src_sel_lo, src_sel_hi;
    logic       cmp_we_lo, cmp_we_hi;
    logic [7:0] cmp_wdata;
    logic       irq_lo, irq_hi;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int n_lo = 0;
    int n_hi = 0;

    itmr_pair dut_i (
        .clk(clk), .rst(rst), .chain_en(chain_en), .div_range(div_range),
        .run_lo(run_lo), .run_hi(run_hi), .src_sel_lo(src_sel_lo),
        .src_sel_hi(src_sel_hi), .cmp_we_lo(cmp_we_lo), .cmp_we_hi(cmp_we_hi),
        .cmp_wdata(cmp_wdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (irq_lo) n_lo <= n_lo + 1;
        if (irq_hi) n_hi <= n_hi + 1;
    end

    // Vector table: kind 0 = lower alone, 1 = upper alone, 2 = chained
    localparam int NV = 11;
    localparam int V_KIND [NV] = '{0, 0, 0, 1, 1, 1, 0, 0, 2, 2, 1};
    localparam int V_SEL  [NV] = '{3, 3, 2, 2, 1, 0, 0, 3, 3, 3, 3};
    localparam int V_RNG  [NV] = '{0, 1, 0, 1, 0, 1, 0, 0, 0, 1, 0};
    localparam int V_CMP  [NV] = '{10, 7, 5, 3, 2, 2, 1, 0, 259, 2, 255};

    function automatic int tick_period(input int sel, input int rng);
        int e;
        case (sel)
            0: e = 11;
            1: e = 7;
            2: e = 5;
            default: e = 3;
        endcase
        return 1 << (e + rng);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    task automatic wait_irq(input int line, input int limit, input string req, output int t);
        bit seen = 0;
        t = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if ((line == 0) ? irq_lo : irq_hi) begin
                t = cyc;
                seen = 1;
                break;
            end
        end
        chk(seen, req, 0, 1);
        if (seen) begin
            @(negedge clk);
            chk(((line == 0) ? irq_lo : irq_hi) == 1'b0, "R3 pulse width", 1, 0);
        end
    endtask

    task automatic write_cmp(input int which, input int val);
        @(negedge clk);
        cmp_wdata = 8'(val);
        cmp_we_lo = (which == 0);
        cmp_we_hi = (which == 1);
        @(negedge clk);
        cmp_we_lo = 1'b0;
        cmp_we_hi = 1'b0;
    endtask

    task automatic stop_all();
        @(negedge clk);
        run_lo = 1'b0;
        run_hi = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_900_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int t0, t1, t2, ts, other, p, ticks, expv, line;
        rst = 1'b1; chain_en = 1'b0; div_range = 1'b0; run_lo = 1'b0; run_hi = 1'b0;
        src_sel_lo = 2'd3; src_sel_hi = 2'd3;
        cmp_we_lo = 1'b0; cmp_we_hi = 1'b0; cmp_wdata = 8'd0;
        repeat (4) @(negedge clk);
        chk(irq_lo == 1'b0 && irq_hi == 1'b0, "R1 irq low in reset", int'(irq_lo | irq_hi), 0);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        chk(n_lo == 0 && n_hi == 0, "R1 idle after reset", n_lo + n_hi, 0);

        // Table walk: R2, R3, R4, R8, R9
        for (int r = 0; r < NV; r++) begin
            stop_all();
            @(negedge clk);
            chain_en   = (V_KIND[r] == 2);
            div_range  = V_RNG[r][0];
            src_sel_lo = 2'(V_SEL[r]);
            src_sel_hi = (V_KIND[r] == 2) ? ~2'(V_SEL[r]) : 2'(V_SEL[r]);
            write_cmp((V_KIND[r] == 1) ? 1 : 0, V_CMP[r] & 255);
            if (V_KIND[r] == 2) write_cmp(1, (V_CMP[r] >> 8) & 255);
            p     = tick_period(V_SEL[r], V_RNG[r]);
            ticks = (V_CMP[r] != 0) ? V_CMP[r] : 256;
            expv  = ticks * p;
            line  = (V_KIND[r] == 0) ? 0 : 1;
            @(negedge clk);
            if (V_KIND[r] == 1) run_hi = 1'b1;
            else                run_lo = 1'b1;
            wait_irq(line, expv + 2 * p + 10, "R2 first match", t0);
            other = (line == 0) ? n_hi : n_lo;
            wait_irq(line, expv + 10, "R3 second match", t1);
            chk(t1 - t0 == expv,
                (V_CMP[r] == 0) ? "R4 wrap period" :
                (V_KIND[r] == 2) ? "R9 chained period" : "R2 R3 period",
                t1 - t0, expv);
            chk(((line == 0) ? n_hi : n_lo) == other,
                (V_KIND[r] == 2) ? "R9 lower line quiet" : "R8 other line quiet",
                ((line == 0) ? n_hi : n_lo) - other, 0);
        end

        // R7: freeze, then restart clears
        stop_all();
        @(negedge clk);
        chain_en = 1'b0; div_range = 1'b0; src_sel_lo = 2'd3;
        write_cmp(0, 10);
        @(negedge clk); run_lo = 1'b1;
        wait_irq(0, 200, "R7 run", t0);
        repeat (40) @(negedge clk);
        run_lo = 1'b0;
        other = n_lo;
        repeat (400) @(negedge clk);
        chk(n_lo == other, "R7 frozen no irq", n_lo - other, 0);
        ts = cyc;
        run_lo = 1'b1;
        wait_irq(0, 200, "R7 restart", t1);
        chk(t1 - ts >= 72 && t1 - ts <= 83, "R7 restart from zero", t1 - ts, 80);

        // R5: immediate compare write shortens the running period
        write_cmp(0, 20);
        wait_irq(0, 200, "R5 sync", t0);
        wait_irq(0, 200, "R5 base", t0);
        repeat (80) @(negedge clk);
        write_cmp(0, 15);
        wait_irq(0, 400, "R5 new match", t1);
        chk(t1 - t0 == 15 * 8, "R5 immediate compare", t1 - t0, 15 * 8);

        // R6: compare written below the count wraps through 255
        repeat (80) @(negedge clk);
        write_cmp(0, 4);
        wait_irq(0, 3000, "R6 wrap match", t2);
        chk(t2 - t1 == 260 * 8, "R6 wrap no spurious", t2 - t1, 260 * 8);

        // R8: both timers running at once with different settings
        stop_all();
        @(negedge clk);
        src_sel_lo = 2'd3; src_sel_hi = 2'd2;
        write_cmp(0, 6);
        write_cmp(1, 3);
        @(negedge clk); run_lo = 1'b1; run_hi = 1'b1;
        wait_irq(0, 200, "R8 lo first", t0);
        wait_irq(0, 200, "R8 lo second", t1);
        chk(t1 - t0 == 48, "R8 lower period", t1 - t0, 48);
        wait_irq(1, 300, "R8 hi first", t0);
        wait_irq(1, 300, "R8 hi second", t1);
        chk(t1 - t0 == 96, "R8 upper period", t1 - t0, 96);

        stop_all();
        finish_run();
    end

endmodule